// File: doc/BRIEF.md
# Interprocessor Interrupt Command Register

This block is the 64-bit command register that software uses to send interrupts from one core to other cores. It sits inside a per-core local interrupt controller. A 32-bit register bus reaches the register through two word offsets. Offset 0x310 holds the upper word, which carries an 8-bit target field in bits 31:24. Offset 0x300 holds the lower word, which carries the message attributes and the destination shorthand.

A write to the lower word starts a message. The block latches the attributes and builds a destination core mask from the shorthand, the target field, the local core ID and the core count. It then holds the message on a valid/ready port. A read-only pending bit in the lower word stays set until the port accepts the message. Software polls this bit before it writes the next command. A logical destination is stored and read back, but it is decoded in the same way as a physical one.

Top module: `ipi_cmd_reg`

## Requirements
- R1: After reset, both words read as zero and `msg_valid` is low.
- R2: A write to offset 0x310 stores wdata[31:24] as the target field. That word reads back as {target, 24'b0}. It never starts a message.
- R3: A write to offset 0x300 while idle raises `msg_valid` after that clock edge. The port then carries the vector (bits 7:0), the mode (bits 10:8, where 000 is fixed, 001 lowest priority, 010 SMI, 100 NMI, 101 INIT, 110 start-up), the level (bit 14) and the trigger (bit 15).
- R4: Bit 12 of the lower word reads 1 while a message is pending. The bit and `msg_valid` both clear after the first clock edge at which `msg_ready` is sampled high. Until then the message holds steady.
- R5: A write to offset 0x300 while a message is pending has no effect on the port or on the readback.
- R6: Shorthand (bits 19:18) value 00 selects only the core whose index equals the target field. Target 0xFF selects all NCORES cores. Any other target at or above NCORES selects none.
- R7: Shorthand 01 selects only the core whose index equals `local_id`.
- R8: Shorthand 10 selects every core. Shorthand 11 selects every core except `local_id`.
- R9: The lower word reads back as {12'b0, shorthand, 2'b0, trigger, level, 1'b0, pending, dest_mode, mode, vector}. All reserved bits read as zero.
- R10: The destination mode bit (bit 11) reads back as written, and the mask is decoded in the same way whatever its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| local_id | input | 8 | Index of this core |
| bus_addr | input | 12 | Byte offset within the controller window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational on bus_addr) |
| msg_valid | output | 1 | Message on the port |
| msg_ready | input | 1 | Port accepts the message |
| msg_vector | output | 8 | Interrupt vector |
| msg_mode | output | 3 | Delivery mode |
| msg_level | output | 1 | Level (1 = assert) |
| msg_trigger | output | 1 | Trigger (1 = level) |
| msg_dest | output | NCORES | Destination core mask |

## Verification
A register write takes effect at the clock edge that samples it. The bench therefore drives each write on a falling edge and checks `msg_valid`, the port fields and the readback at the next falling edge. That point is one register stage later. Readback is combinational on the address, so it is sampled a short delay after the address is set. An acceptance clears the pending state at the edge where ready is high, and the bench checks for that clearance at the falling edge that follows.

// File: rtl/ipi_cmd_reg.sv
module ipi_cmd_reg #(
  parameter int NCORES = 8,
  parameter int AW = 12,
  parameter logic [AW-1:0] LO_OFS = 'h300,
  parameter logic [AW-1:0] HI_OFS = 'h310
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        local_id,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [7:0]        msg_vector,
  output logic [2:0]        msg_mode,
  output logic              msg_level,
  output logic              msg_trigger,
  output logic [NCORES-1:0] msg_dest
);

  logic [7:0]        tgt_q;
  logic [7:0]        vec_q;
  logic [2:0]        mode_q;
  logic              dm_q, lvl_q, trg_q, pend_q;
  logic [1:0]        sh_q;
  logic [NCORES-1:0] mask_q, mask_d;

  wire wr_lo  = bus_wr && bus_addr == LO_OFS;
  wire wr_hi  = bus_wr && bus_addr == HI_OFS;
  wire launch = wr_lo && !pend_q;
  wire [1:0] sh_d = bus_wdata[19:18];

  for (genvar i = 0; i < NCORES; i++) begin : g_mask
    wire hit_tgt  = tgt_q == 8'hFF || tgt_q == 8'(i);
    wire hit_self = local_id == 8'(i);
    assign mask_d[i] = (sh_d == 2'b00) ? hit_tgt  :
                       (sh_d == 2'b01) ? hit_self :
                       (sh_d == 2'b10) ? 1'b1     : !hit_self;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_q <= '0; vec_q <= '0; mode_q <= '0; dm_q <= 1'b0;
      lvl_q <= 1'b0; trg_q <= 1'b0; sh_q <= '0; pend_q <= 1'b0;
      mask_q <= '0;
    end else begin
      if (wr_hi) tgt_q <= bus_wdata[31:24];
      if (launch) begin
        vec_q  <= bus_wdata[7:0];
        mode_q <= bus_wdata[10:8];
        dm_q   <= bus_wdata[11];
        lvl_q  <= bus_wdata[14];
        trg_q  <= bus_wdata[15];
        sh_q   <= sh_d;
        mask_q <= mask_d;
        pend_q <= 1'b1;
      end else if (pend_q && msg_ready) begin
        pend_q <= 1'b0;
      end
    end
  end

  wire [31:0] lo_word = {12'b0, sh_q, 2'b0, trg_q, lvl_q, 1'b0, pend_q, dm_q, mode_q, vec_q};
  wire [31:0] hi_word = {tgt_q, 24'b0};

  assign bus_rdata   = (bus_addr == LO_OFS) ? lo_word :
                       (bus_addr == HI_OFS) ? hi_word : 32'b0;
  assign msg_valid   = pend_q;
  assign msg_vector  = vec_q;
  assign msg_mode    = mode_q;
  assign msg_level   = lvl_q;
  assign msg_trigger = trg_q;
  assign msg_dest    = mask_q;

  p_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !msg_valid) |=> msg_valid);
  p_hi_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !msg_valid) |=> !msg_valid);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> msg_valid && $stable(msg_vector) && $stable(msg_mode) && $stable(msg_dest));
  p_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready && !bus_wr) |=> !msg_valid);
  p_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && wr_lo) |=> $stable(msg_vector) && $stable(msg_level) && $stable(msg_trigger));
  p_self_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && bus_rdata[19:18] == 2'b01 && bus_addr == LO_OFS) |-> $countones(msg_dest) <= 1);
  p_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && bus_addr == LO_OFS && bus_rdata[19:18] == 2'b10) |-> &msg_dest);

endmodule

// File: tb/ipi_cmd_reg_test.sv
module ipi_cmd_reg_test;
  localparam int NC = 8;
  localparam logic [11:0] LO = 12'h300, HI = 12'h310;

  logic clk = 0, rst_n = 0, bus_wr = 0, msg_ready = 0;
  logic [7:0] local_id = 0;
  logic [11:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic msg_valid, msg_level, msg_trigger;
  logic [7:0] msg_vector;
  logic [2:0] msg_mode;
  logic [NC-1:0] msg_dest;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  ipi_cmd_reg #(.NCORES(NC)) uut (.*);

  function automatic logic [NC-1:0] exp_mask(input logic [1:0] sh, input logic [7:0] tgt, input logic [7:0] id);
    logic [NC-1:0] m = '0;
    for (int i = 0; i < NC; i++)
      case (sh)
        2'b00: m[i] = (tgt == 8'hFF) || (tgt == 8'(i));
        2'b01: m[i] = (id == 8'(i));
        2'b10: m[i] = 1'b1;
        default: m[i] = (id != 8'(i));
      endcase
    return m;
  endfunction

  function automatic logic [31:0] exp_lo(input logic [31:0] w, input logic pend);
    return {12'b0, w[19:18], 2'b0, w[15], w[14], 1'b0, pend, w[11], w[10:8], w[7:0]};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a; #1 d = bus_rdata;
  endtask

  logic [7:0] tgt_m;

  task automatic run_cmd(input logic [7:0] tgt, input logic [31:0] lo, input int wait_n, input bit poke);
    logic [31:0] r;
    logic [NC-1:0] em;
    wr(HI, {tgt, 24'($urandom)});
    tgt_m = tgt;
    chk(!msg_valid, "R2 no launch", 32'(msg_valid), 0);
    rd(HI, r); chk(r == {tgt, 24'b0}, "R2 high readback", r, {tgt, 24'b0});
    wr(LO, lo);
    em = exp_mask(lo[19:18], tgt, local_id);
    chk(msg_valid, "R3 valid", 32'(msg_valid), 1);
    chk({msg_vector, msg_mode, msg_level, msg_trigger} == {lo[7:0], lo[10:8], lo[14], lo[15]},
        "R3 fields", {19'b0, msg_vector, msg_mode, msg_level, msg_trigger}, {19'b0, lo[7:0], lo[10:8], lo[14], lo[15]});
    chk(msg_dest == em, lo[19:18] == 0 ? "R6 mask" : lo[19:18] == 1 ? "R7 mask" : "R8 mask", 32'(msg_dest), 32'(em));
    rd(LO, r); chk(r == exp_lo(lo, 1), "R9 R10 R4 low readback", r, exp_lo(lo, 1));
    for (int k = 0; k < wait_n; k++) @(negedge clk);
    chk(msg_valid, "R4 held", 32'(msg_valid), 1);
    if (poke) begin
      wr(LO, ~lo);
      chk({msg_vector, msg_level, msg_trigger, msg_dest} == {lo[7:0], lo[14], lo[15], em}, "R5 ignored",
          {msg_vector, msg_level, msg_trigger, msg_dest}, {lo[7:0], lo[14], lo[15], em});
      rd(LO, r); chk(r == exp_lo(lo, 1), "R5 readback", r, exp_lo(lo, 1));
    end
    @(negedge clk); msg_ready = 1;
    @(negedge clk); msg_ready = 0;
    chk(!msg_valid, "R4 cleared", 32'(msg_valid), 0);
    rd(LO, r); chk(r[12] == 0, "R4 status idle", r, exp_lo(lo, 0));
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(LO, r); chk(r == 0, "R1 low reset", r, 0);
    rd(HI, r); chk(r == 0, "R1 high reset", r, 0);
    chk(!msg_valid, "R1 valid reset", 32'(msg_valid), 0);
    local_id = 8'd3;
    run_cmd(8'hFF, 32'h0000_C500, 0, 0);
    run_cmd(8'd20, 32'h0000_4611, 1, 0);
    run_cmd(8'd5, 32'h0000_0821, 2, 1);
    local_id = NC - 1;
    run_cmd(8'd0, 32'h0004_8433, 0, 0);
    run_cmd(8'd2, 32'h000C_4611, 0, 1);
    run_cmd(8'd2, 32'h0008_0001, 0, 0);
    for (int t = 0; t < 60; t++) begin
      logic [7:0] tg;
      local_id = 8'($urandom % NC);
      case ($urandom % 3)
        0: tg = 8'($urandom % NC);
        1: tg = 8'hFF;
        default: tg = 8'(NC + ($urandom % (255 - NC)));
      endcase
      run_cmd(tg, $urandom, $urandom % 4, t[0]);
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule